// File: doc/BRIEF.md
# MSI capture interrupt controller

This block turns inbound message-signalled interrupt writes into per-vector pending status and one interrupt line. Each inbound write arrives as a single-cycle strobe with a 64-bit address and 32-bit data. When the address equals the programmed 64-bit target address, the data value is taken as a vector number. The status bit for that vector is set, provided the vector is enabled.

Vectors are grouped into banks of 32. Each bank has three 32-bit registers: enable, mask and write-one-to-clear status. Software reaches these registers, together with the two target-address words, over a simple 32-bit register port. Reads on that port are combinational from the address. The single interrupt output stays high while any status bit is set and not masked.

Top module: `msi_irq_ctrl`

## Requirements
- R1: After reset, every implemented register reads zero and `irq_o` is low.
- R2: The target address is read/write: low word at byte offset 0x820, high word at 0x824. Bank enable and mask registers are read/write.
- R3: Bank b has its enable at 0x828+12*b, its mask at 0x82C+12*b and its status at 0x830+12*b. Vector n lives in bank n/32, bit n%32.
- R4: An inbound write sets status bit n one cycle later when all of these hold: the 64-bit address equals {high word, low word}, the data equals n, n is below NUM_BANKS*32, and enable bit n is 1.
- R5: An inbound write whose address differs from the target in either word leaves all status unchanged.
- R6: An inbound write to a disabled vector, or one whose data is NUM_BANKS*32 or above, leaves all status unchanged. The data is never truncated.
- R7: Writing a status register clears each bit written as 1 and keeps each bit written as 0. Software cannot set a status bit.
- R8: If an inbound set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R9: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0. It follows register updates in the same cycle they take effect.
- R10: Offsets that are not implemented, including offsets that are not word aligned, read zero. Writes to them change nothing.
- R11: Clearing an enable bit keeps that vector's pending status. It only blocks new sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msi_valid_i | input | 1 | Inbound write strobe |
| msi_addr_i | input | 64 | Inbound write address |
| msi_data_i | input | 32 | Inbound write data (vector number) |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Register write when 1 |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
All pending state is visible at the ports. A status bit that is wrongly set or lost shows in the bank's status readback, and in `irq_o` when the bit is unmasked, one cycle after the inbound write or clear that caused it. A wrong bank mapping shows as a set bit in a neighbouring bank's word. A wrong address or enable gate shows as status that changed when it should have stayed stable. Both are visible on the next readback.

// File: rtl/msi_irq_pkg.sv
`timescale 1ns/1ps
package msi_irq_pkg;
  localparam int unsigned REG_AW      = 12;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned BANK_VECS   = 32;
  localparam int unsigned BANK_STRIDE = 12;
  localparam logic [REG_AW-1:0] TGT_LO_OFF  = 12'h820;
  localparam logic [REG_AW-1:0] TGT_HI_OFF  = 12'h824;
  localparam logic [REG_AW-1:0] BANK_EN_OFF = 12'h828;
  localparam logic [REG_AW-1:0] BANK_MK_OFF = 12'h82C;
  localparam logic [REG_AW-1:0] BANK_ST_OFF = 12'h830;

  typedef enum logic [1:0] {
    FLD_EN = 2'd0,
    FLD_MK = 2'd1,
    FLD_ST = 2'd2
  } bank_fld_e;
endpackage

// File: rtl/msi_reg_decode.sv
`timescale 1ns/1ps
module msi_reg_decode
  import msi_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic [REG_AW-1:0]    addr_i,
  output logic                 sel_lo_o,
  output logic                 sel_hi_o,
  output logic [NUM_BANKS-1:0] sel_en_o,
  output logic [NUM_BANKS-1:0] sel_mk_o,
  output logic [NUM_BANKS-1:0] sel_st_o
);
  assign sel_lo_o = (addr_i == TGT_LO_OFF);
  assign sel_hi_o = (addr_i == TGT_HI_OFF);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_sel
    localparam logic [REG_AW-1:0] BASE = REG_AW'(BANK_STRIDE * b);
    assign sel_en_o[b] = (addr_i == BANK_EN_OFF + BASE);
    assign sel_mk_o[b] = (addr_i == BANK_MK_OFF + BASE);
    assign sel_st_o[b] = (addr_i == BANK_ST_OFF + BASE);
  end
endmodule

// File: rtl/msi_match.sv
`timescale 1ns/1ps
module msi_match
  import msi_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned NVEC     = NUM_BANKS * BANK_VECS,
  localparam int unsigned VW       = $clog2(NVEC)
) (
  input  logic              msi_valid_i,
  input  logic [63:0]       msi_addr_i,
  input  logic [WORD_W-1:0] msi_data_i,
  input  logic [WORD_W-1:0] tgt_lo_i,
  input  logic [WORD_W-1:0] tgt_hi_i,
  output logic [NVEC-1:0]   set_o
);
  logic addr_hit, vec_ok;
  logic [VW-1:0] vec;

  assign addr_hit = (msi_addr_i == {tgt_hi_i, tgt_lo_i});
  assign vec_ok   = (msi_data_i < WORD_W'(NVEC));
  assign vec      = msi_data_i[VW-1:0];

  always_comb begin
    set_o = '0;
    if (msi_valid_i && addr_hit && vec_ok) set_o[vec] = 1'b1;
  end
endmodule

// File: rtl/msi_bank.sv
`timescale 1ns/1ps
module msi_bank
  import msi_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_we_i,
  input  logic                 mk_we_i,
  input  logic                 st_we_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic [BANK_VECS-1:0] set_i,
  output logic [WORD_W-1:0]    en_o,
  output logic [WORD_W-1:0]    mk_o,
  output logic [WORD_W-1:0]    st_o,
  output logic                 pend_o
);
  logic [BANK_VECS-1:0] clr, set_gated;

  assign clr       = st_we_i ? wdata_i : '0;
  // Gate with the pre-update enable: a write to enable takes effect next cycle
  assign set_gated = set_i & en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= '0;
      mk_o <= '0;
      st_o <= '0;
    end else begin
      if (en_we_i) en_o <= wdata_i;
      if (mk_we_i) mk_o <= wdata_i;
      // set after clear: a simultaneous set wins
      st_o <= (st_o & ~clr) | set_gated;
    end
  end

  assign pend_o = |(st_o & ~mk_o);
endmodule

// File: rtl/msi_irq_ctrl.sv
`timescale 1ns/1ps
module msi_irq_ctrl
  import msi_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned NVEC     = NUM_BANKS * BANK_VECS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msi_valid_i,
  input  logic [63:0]       msi_addr_i,
  input  logic [WORD_W-1:0] msi_data_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic                 sel_lo, sel_hi, wr;
  logic [NUM_BANKS-1:0] sel_en, sel_mk, sel_st, pend;
  logic [WORD_W-1:0]    tgt_lo, tgt_hi;
  logic [NVEC-1:0]      set_vec, en_all, mk_all, st_all;

  assign wr = reg_req_i & reg_we_i;

  msi_reg_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .addr_i   (reg_addr_i),
    .sel_lo_o (sel_lo),
    .sel_hi_o (sel_hi),
    .sel_en_o (sel_en),
    .sel_mk_o (sel_mk),
    .sel_st_o (sel_st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_lo <= '0;
      tgt_hi <= '0;
    end else begin
      if (wr && sel_lo) tgt_lo <= reg_wdata_i;
      if (wr && sel_hi) tgt_hi <= reg_wdata_i;
    end
  end

  msi_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .msi_valid_i (msi_valid_i),
    .msi_addr_i  (msi_addr_i),
    .msi_data_i  (msi_data_i),
    .tgt_lo_i    (tgt_lo),
    .tgt_hi_i    (tgt_hi),
    .set_o       (set_vec)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    msi_bank u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_we_i (wr & sel_en[b]),
      .mk_we_i (wr & sel_mk[b]),
      .st_we_i (wr & sel_st[b]),
      .wdata_i (reg_wdata_i),
      .set_i   (set_vec[b*BANK_VECS +: BANK_VECS]),
      .en_o    (en_all[b*BANK_VECS +: BANK_VECS]),
      .mk_o    (mk_all[b*BANK_VECS +: BANK_VECS]),
      .st_o    (st_all[b*BANK_VECS +: BANK_VECS]),
      .pend_o  (pend[b])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (sel_lo) reg_rdata_o = tgt_lo;
    if (sel_hi) reg_rdata_o = tgt_hi;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_en[b]) reg_rdata_o = en_all[b*BANK_VECS +: BANK_VECS];
      if (sel_mk[b]) reg_rdata_o = mk_all[b*BANK_VECS +: BANK_VECS];
      if (sel_st[b]) reg_rdata_o = st_all[b*BANK_VECS +: BANK_VECS];
    end
  end

  assign irq_o = |pend;
endmodule

// File: rtl/msi_irq_ctrl_chk.sv
`timescale 1ns/1ps
module msi_irq_ctrl_chk
  import msi_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned NVEC     = NUM_BANKS * BANK_VECS,
  localparam int unsigned VW       = $clog2(NVEC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              msi_valid_i,
  input logic [63:0]       msi_addr_i,
  input logic [WORD_W-1:0] msi_data_i,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic              irq_o,
  input logic [WORD_W-1:0] tgt_lo,
  input logic [WORD_W-1:0] tgt_hi,
  input logic [NVEC-1:0]   en_all,
  input logic [NVEC-1:0]   mk_all,
  input logic [NVEC-1:0]   st_all
);
  logic hit, sw_wr;
  logic [VW-1:0] vec;

  assign hit   = msi_valid_i && (msi_addr_i == {tgt_hi, tgt_lo}) && (msi_data_i < WORD_W'(NVEC));
  assign vec   = msi_data_i[VW-1:0];
  assign sw_wr = reg_req_i && reg_we_i;

  // R4
  set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && en_all[vec] |=> st_all[$past(vec)]);

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && en_all[vec] && sw_wr |=> st_all[$past(vec)]);

  // R5
  addr_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_valid_i && (msi_addr_i != {tgt_hi, tgt_lo}) && !sw_wr |=> $stable(st_all));

  // R6
  disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !en_all[vec] && !sw_wr |=> $stable(st_all));

  // R7
  no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msi_valid_i |=> ((st_all & ~$past(st_all)) == '0));

  // R9
  mask_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mk_all) |-> !irq_o);
endmodule

bind msi_irq_ctrl msi_irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msi_valid_i (msi_valid_i),
  .msi_addr_i  (msi_addr_i),
  .msi_data_i  (msi_data_i),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .irq_o       (irq_o),
  .tgt_lo      (tgt_lo),
  .tgt_hi      (tgt_hi),
  .en_all      (en_all),
  .mk_all      (mk_all),
  .st_all      (st_all)
);

// File: tb/sim_msi_irq_ctrl.sv
`timescale 1ns/1ps
module sim_msi_irq_ctrl;
  localparam int NB   = 8;
  localparam int NVEC = NB * 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msi_valid_i = 1'b0;
  logic [63:0] msi_addr_i = '0;
  logic [31:0] msi_data_i = '0;
  logic        reg_req_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  always #2.5 clk_i = ~clk_i;

  msi_irq_ctrl #(.NUM_BANKS(NB)) u0 (.*);

  int errs = 0, checks = 0;
  logic [31:0] m_lo = '0, m_hi = '0;
  logic [31:0] m_en [NB];
  logic [31:0] m_mk [NB];
  logic [31:0] m_st [NB];

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [31:0] r = '0;
    if (a == 12'h820) r = m_lo;
    if (a == 12'h824) r = m_hi;
    for (int b = 0; b < NB; b++) begin
      if (a == 12'(12'h828 + 12*b)) r = m_en[b];
      if (a == 12'(12'h82C + 12*b)) r = m_mk[b];
      if (a == 12'(12'h830 + 12*b)) r = m_st[b];
    end
    return r;
  endfunction

  function automatic bit m_irq();
    bit r = 0;
    for (int b = 0; b < NB; b++) if ((m_st[b] & ~m_mk[b]) != 0) r = 1;
    return r;
  endfunction

  task automatic step(input bit mv, input logic [63:0] ma, input logic [31:0] md,
                      input bit we, input logic [11:0] ra, input logic [31:0] wd);
    logic [31:0] setw [NB];
    @(negedge clk_i);
    msi_valid_i = mv; msi_addr_i = ma; msi_data_i = md;
    reg_req_i = we; reg_we_i = we; reg_addr_i = ra; reg_wdata_i = wd;
    @(posedge clk_i);
    for (int b = 0; b < NB; b++) setw[b] = '0;
    if (mv && ma == {m_hi, m_lo} && md < NVEC && m_en[md/32][md%32])
      setw[md/32][md%32] = 1'b1;
    if (we) begin
      if (ra == 12'h820) m_lo = wd;
      if (ra == 12'h824) m_hi = wd;
    end
    for (int b = 0; b < NB; b++) begin
      logic [31:0] clr = '0;
      if (we && ra == 12'(12'h828 + 12*b)) m_en[b] = wd;
      if (we && ra == 12'(12'h82C + 12*b)) m_mk[b] = wd;
      if (we && ra == 12'(12'h830 + 12*b)) clr = wd;
      m_st[b] = (m_st[b] & ~clr) | setw[b];
    end
    #1;
    msi_valid_i = 0; reg_req_i = 0; reg_we_i = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(0, '0, '0, 1, a, d);
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    step(1, a, d, 0, '0, '0);
  endtask

  task automatic chk_rd(input logic [11:0] a, input string req);
    @(negedge clk_i);
    reg_addr_i = a;
    #1;
    check(reg_rdata_o === m_read(a), req, reg_rdata_o, m_read(a));
  endtask

  task automatic chk_irq(input string req);
    check(irq_o === m_irq(), req, {31'd0, irq_o}, {31'd0, m_irq()});
  endtask

  localparam logic [63:0] TGT = 64'h0000_0001_FEE0_1000;

  initial begin
    #(200000 * 5);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_en[b] = '0; m_mk[b] = '0; m_st[b] = '0; end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    chk_rd(12'h820, "R1"); chk_rd(12'h824, "R1");
    for (int b = 0; b < NB; b++) begin
      chk_rd(12'(12'h828 + 12*b), "R1");
      chk_rd(12'(12'h82C + 12*b), "R1");
      chk_rd(12'(12'h830 + 12*b), "R1");
    end
    chk_irq("R1");

    // R2 target and enable programming
    wr(12'h820, TGT[31:0]); wr(12'h824, TGT[63:32]);
    chk_rd(12'h820, "R2"); chk_rd(12'h824, "R2");
    wr(12'h828, 32'hFFFF_FFFF);
    wr(12'(12'h828 + 12*7), 32'h8000_0000);
    chk_rd(12'h828, "R2"); chk_rd(12'(12'h828 + 84), "R2");

    // R4 set by matching write
    msi(TGT, 32'd5);
    chk_rd(12'h830, "R4"); chk_irq("R4"); chk_irq("R9");
    check(reg_rdata_o === 32'h20, "R4", reg_rdata_o, 32'h20);

    // R3 last vector lands in last bank, top bit
    msi(TGT, 32'd255);
    chk_rd(12'h884, "R3");
    check(reg_rdata_o === 32'h8000_0000, "R3", reg_rdata_o, 32'h8000_0000);

    // R5 address mismatch in either word
    msi({TGT[63:32] ^ 32'h1, TGT[31:0]}, 32'd6);
    msi({TGT[63:32], TGT[31:0] ^ 32'h4}, 32'd7);
    chk_rd(12'h830, "R5");

    // R6 disabled vector and out-of-range data
    msi(TGT, 32'd40);
    chk_rd(12'h83C, "R6");
    msi(TGT, 32'd256);
    chk_rd(12'h830, "R6");
    check(reg_rdata_o[0] === 1'b0, "R6", reg_rdata_o, 32'h20);

    // R9 masking
    wr(12'h82C, 32'hFFFF_FFFF);
    chk_irq("R9");
    wr(12'(12'h82C + 84), 32'h8000_0000);
    chk_irq("R9");
    check(irq_o === 1'b0, "R9", {31'd0, irq_o}, 32'd0);
    wr(12'h82C, 32'h0);
    chk_irq("R9");

    // R7 write-one-to-clear
    wr(12'h830, 32'h0000_0001);
    chk_rd(12'h830, "R7");
    wr(12'h830, 32'h0000_0020);
    chk_rd(12'h830, "R7");
    check(reg_rdata_o === 32'h0, "R7", reg_rdata_o, 32'h0);

    // R8 set beats simultaneous clear
    step(1, TGT, 32'd7, 1, 12'h830, 32'h0000_0080);
    chk_rd(12'h830, "R8");
    check(reg_rdata_o === 32'h80, "R8", reg_rdata_o, 32'h80);

    // R10 unimplemented offsets
    wr(12'h888, 32'hDEAD_BEEF);
    wr(12'h822, 32'h1234_5678);
    chk_rd(12'h888, "R10"); chk_rd(12'h81C, "R10"); chk_rd(12'h822, "R10");
    chk_rd(12'h820, "R10");
    check(reg_rdata_o === TGT[31:0], "R10", reg_rdata_o, TGT[31:0]);

    // R11 disabling keeps pending status
    wr(12'h828, 32'h0);
    chk_rd(12'h830, "R11");
    check(reg_rdata_o === 32'h80, "R11", reg_rdata_o, 32'h80);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit mv = ($urandom % 3) != 0;
      bit we = ($urandom % 2) != 0;
      logic [63:0] ma = (($urandom % 8) == 0) ? {$urandom, $urandom} : {m_hi, m_lo};
      logic [31:0] md = $urandom % (NVEC + 16);
      int sel = $urandom % 40;
      int bk = $urandom % NB;
      logic [11:0] ra;
      logic [31:0] wd = $urandom;
      if (sel == 0) ra = 12'h820;
      else if (sel < 12) ra = 12'(12'h828 + 12*bk);
      else if (sel < 20) ra = 12'(12'h82C + 12*bk);
      else if (sel < 36) ra = 12'(12'h830 + 12*bk);
      else ra = 12'h800 + 12'($urandom % 160);
      if (($urandom % 4) != 0) wd = wd & $urandom;
      step(mv, ma, md, we, ra, wd);
      chk_irq("R9");
      chk_rd(12'(12'h830 + 12*($urandom % NB)), "R4");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule